// File: doc/BRIEF.md
# Interrupt Remapping Entry Lookup

This block sits between an I/O interrupt controller and the interrupt delivery fabric. The controller hands it a 64-bit redirection request in remappable form, and the block turns that request into a set of delivery attributes. It screens the request, derives a 16-bit handle, and fetches the matching 128-bit descriptor from a table held in system memory. The table starts at a programmed base address. The block then checks the descriptor and returns the translated trigger mode, vector, delivery mode, destination and destination mode. When something is wrong it returns a fault code instead.

A single translation is in flight at a time. The controller side uses a valid/ready request and a one-cycle response pulse. The memory side issues one read request with valid/ready and accepts one read return that carries a data word and an error flag. The memory must return at least one cycle after it accepts the read.

Request layout: vector hint [7:0], must-be-zero [10:8], handle high bit [11], must-be-zero [14:12], trigger mode [15], must-be-zero [47:16], format [48], handle low bits [63:49].

Descriptor layout: present [0], destination mode [1], trigger mode [4], delivery mode [7:5], vector [23:16], and a 32-bit destination word at [63:32] whose byte [47:40] is the target. Reserved bits: [3:2], [15:8], [31:24], [39:32], [63:48] and [127:64].

Top module: `irq_remap_lookup`

## Requirements
- R1: A request with format bit [48] = 0 gets fault code 1 (legacy format) and issues no memory read. This check takes priority over every other check.
- R2: A request with format bit = 1 and any nonzero bit in [10:8], [14:12] or [47:16] gets fault code 2 (request reserved) and issues no memory read.
- R3: The handle is {req[11], req[63:49]}. The read address is root_base + handle × 16, sampled when the request is accepted. mem_rd_valid and mem_rd_addr stay stable until mem_rd_ready is seen.
- R4: A read return with mem_rsp_err = 1 gives fault code 3 (root invalid). Otherwise a descriptor with present bit [0] = 0 gives fault code 4 (absent). The priority order is 3, then 4, then 5, then 6.
- R5: A present descriptor with any reserved bit set gives fault code 5 (descriptor reserved).
- R6: On success (fault code 0) the outputs are as follows. rsp_trig comes from descriptor bit [4]. rsp_dlv comes from [7:5]. rsp_vec comes from [23:16]. rsp_dmode comes from [1]. rsp_dest comes from bits [15:8] of the destination word, which is descriptor [47:40].
- R7: If request bit [15] differs from descriptor bit [4], the result is fault code 6 (trigger mismatch).
- R8: If the request vector differs from the descriptor vector, the translation still succeeds with the descriptor's vector and rsp_vec_warn = 1. Otherwise rsp_vec_warn = 0. On any fault, all translated fields and rsp_vec_warn are 0.
- R9: req_ready is low while remap_en is low. Presenting a request while remapping is disabled is a caller error.
- R10: Each accepted request produces exactly one rsp_valid pulse, one cycle wide. req_ready stays low from acceptance through the response cycle.
- R11: Synchronous active-high reset returns the block to idle, even in the middle of a translation. After reset there is no response, no pending read, and req_ready follows remap_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| remap_en | input | 1 | Remapping enabled |
| root_base | input | ADDR_W | Byte address of table entry 0 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_entry | input | 64 | Remappable-form request |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_fault | output | 3 | 0 ok, 1 legacy, 2 req reserved, 3 root invalid, 4 absent, 5 desc reserved, 6 trigger mismatch |
| rsp_trig | output | 1 | Translated trigger mode |
| rsp_vec | output | 8 | Translated vector |
| rsp_dlv | output | 3 | Translated delivery mode |
| rsp_dest | output | 8 | Translated destination |
| rsp_dmode | output | 1 | Translated destination mode |
| rsp_vec_warn | output | 1 | Request vector disagreed with table |
| mem_rd_valid | output | 1 | Read request |
| mem_rd_ready | input | 1 | Read request taken |
| mem_rd_addr | output | ADDR_W | Read byte address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_err | input | 1 | Read failed |
| mem_rsp_data | input | 128 | Descriptor |

## Verification
Three kinds of internal fault show up at the ports, each within a bounded time:

- **Wrong handle assembly or base capture:** mem_rd_addr is wrong in the first cycle after acceptance.
- **Wrong sequencer state:** the response pulse is missing, doubled or early, or req_ready rises while a read is still outstanding. This is visible within one or two cycles of the read handshake.
- **Mis-ordered checks in the screening logic:** the wrong fault code appears in the single response cycle. The vectors are chosen so that several faults coincide.

// File: rtl/irq_remap_pkg.sv
package irq_remap_pkg;

  localparam int REQ_W     = 64;
  localparam int ENT_W     = 128;
  localparam int IDX_W     = 16;
  localparam int ENT_SHIFT = 4;   // log2 of descriptor size in bytes

  // request bits that must be zero in remappable form
  localparam logic [REQ_W-1:0] REQ_RSVD_MASK = 64'h0000_FFFF_FFFF_7700;
  // descriptor bits that must be zero without extended destinations
  localparam logic [ENT_W-1:0] ENT_RSVD_MASK =
    128'hFFFF_FFFF_FFFF_FFFF_FFFF_00FF_FF00_FF0C;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_COMPAT   = 3'd1,
    FLT_REQ_RSVD = 3'd2,
    FLT_ROOT     = 3'd3,
    FLT_ABSENT   = 3'd4,
    FLT_ENT_RSVD = 3'd5,
    FLT_TRIG     = 3'd6
  } fault_e;

  typedef struct packed {
    logic       trig;
    logic [2:0] dlv;
    logic [7:0] vec;
    logic [7:0] dest;
    logic       dmode;
  } xlat_t;

endpackage

// File: rtl/irq_req_decode.sv
module irq_req_decode
  import irq_remap_pkg::*;
(
  input  logic [REQ_W-1:0] req,
  output fault_e           pre_fault,
  output logic [IDX_W-1:0] idx,
  output logic             trig,
  output logic [7:0]       vec
);

  always_comb begin
    idx  = {req[11], req[63:49]};
    trig = req[15];
    vec  = req[7:0];
    if (!req[48])
      pre_fault = FLT_COMPAT;
    else if (|(req & REQ_RSVD_MASK))
      pre_fault = FLT_REQ_RSVD;
    else
      pre_fault = FLT_NONE;
  end

endmodule

// File: rtl/irq_ent_check.sv
module irq_ent_check
  import irq_remap_pkg::*;
(
  input  logic [ENT_W-1:0] ent,
  input  logic             rd_err,
  input  logic             req_trig,
  input  logic [7:0]       req_vec,
  output fault_e           fault,
  output xlat_t            xl,
  output logic             warn
);

  xlat_t fields;

  always_comb begin
    fields.trig  = ent[4];
    fields.dlv   = ent[7:5];
    fields.vec   = ent[23:16];
    fields.dest  = ent[47:40];
    fields.dmode = ent[1];

    if (rd_err)
      fault = FLT_ROOT;
    else if (!ent[0])
      fault = FLT_ABSENT;
    else if (|(ent & ENT_RSVD_MASK))
      fault = FLT_ENT_RSVD;
    else if (fields.trig != req_trig)
      fault = FLT_TRIG;
    else
      fault = FLT_NONE;

    if (fault == FLT_NONE) begin
      xl   = fields;
      warn = (fields.vec != req_vec);
    end else begin
      xl   = '0;
      warn = 1'b0;
    end
  end

endmodule

// File: rtl/irq_remap_lookup.sv
module irq_remap_lookup
  import irq_remap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              remap_en,
  input  logic [ADDR_W-1:0] root_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_entry,
  output logic              rsp_valid,
  output logic [2:0]        rsp_fault,
  output logic              rsp_trig,
  output logic [7:0]        rsp_vec,
  output logic [2:0]        rsp_dlv,
  output logic [7:0]        rsp_dest,
  output logic              rsp_dmode,
  output logic              rsp_vec_warn,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  input  logic [127:0]      mem_rsp_data
);

  localparam int OFS_W = IDX_W + ENT_SHIFT;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WT, ST_RSP} state_e;

  state_e            st;
  logic [ADDR_W-1:0] addr_q;
  logic              trig_q;
  logic [7:0]        vec_q;
  fault_e            fault_q;
  xlat_t             xl_q;
  logic              warn_q;
  logic              rsp_q;

  fault_e           dec_fault;
  logic [IDX_W-1:0] dec_idx;
  logic             dec_trig;
  logic [7:0]       dec_vec;

  fault_e chk_fault;
  xlat_t  chk_xl;
  logic   chk_warn;

  logic             accept;
  logic [OFS_W-1:0] ofs;

  irq_req_decode u_dec (
    .req       (req_entry),
    .pre_fault (dec_fault),
    .idx       (dec_idx),
    .trig      (dec_trig),
    .vec       (dec_vec)
  );

  irq_ent_check u_chk (
    .ent      (mem_rsp_data),
    .rd_err   (mem_rsp_err),
    .req_trig (trig_q),
    .req_vec  (vec_q),
    .fault    (chk_fault),
    .xl       (chk_xl),
    .warn     (chk_warn)
  );

  assign req_ready = (st == ST_IDLE) && remap_en;
  assign accept    = req_valid && req_ready;
  assign ofs       = {dec_idx, {ENT_SHIFT{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      addr_q  <= '0;
      trig_q  <= 1'b0;
      vec_q   <= '0;
      fault_q <= FLT_NONE;
      xl_q    <= '0;
      warn_q  <= 1'b0;
      rsp_q   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          trig_q <= dec_trig;
          vec_q  <= dec_vec;
          if (dec_fault != FLT_NONE) begin
            fault_q <= dec_fault;
            xl_q    <= '0;
            warn_q  <= 1'b0;
            rsp_q   <= 1'b1;
            st      <= ST_RSP;
          end else begin
            addr_q <= root_base + ADDR_W'(ofs);
            st     <= ST_RD;
          end
        end
        ST_RD: if (mem_rd_ready) st <= ST_WT;
        ST_WT: if (mem_rsp_valid) begin
          fault_q <= chk_fault;
          xl_q    <= chk_xl;
          warn_q  <= chk_warn;
          rsp_q   <= 1'b1;
          st      <= ST_RSP;
        end
        default: begin
          rsp_q <= 1'b0;
          st    <= ST_IDLE;
        end
      endcase
    end
  end

  assign mem_rd_valid = (st == ST_RD);
  assign mem_rd_addr  = addr_q;
  assign rsp_valid    = rsp_q;
  assign rsp_fault    = fault_q;
  assign rsp_trig     = xl_q.trig;
  assign rsp_vec      = xl_q.vec;
  assign rsp_dlv      = xl_q.dlv;
  assign rsp_dest     = xl_q.dest;
  assign rsp_dmode    = xl_q.dmode;
  assign rsp_vec_warn = warn_q;

  AST_CALLER_ENABLED: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> remap_en); // R9

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R10

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready); // R10

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R3

  AST_PREFAULT_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (accept && dec_fault != FLT_NONE) |=> (rsp_valid && !mem_rd_valid)); // R1 R2

  AST_WARN_ON_SUCCESS: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_vec_warn) |-> (rsp_fault == 3'd0)); // R8

  AST_RSP_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
    (mem_rsp_valid && st == ST_WT) |=> rsp_valid); // R4

endmodule

// File: tb/irq_remap_lookup_bench.sv
module irq_remap_lookup_bench;

  localparam int          ADDR_W = 32;
  localparam logic [31:0] BASE   = 32'h0010_0000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              remap_en = 1'b1;
  logic [ADDR_W-1:0] root_base = BASE;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [63:0]       req_entry = '0;
  logic              rsp_valid;
  logic [2:0]        rsp_fault;
  logic              rsp_trig;
  logic [7:0]        rsp_vec;
  logic [2:0]        rsp_dlv;
  logic [7:0]        rsp_dest;
  logic              rsp_dmode;
  logic              rsp_vec_warn;
  logic              mem_rd_valid;
  logic              mem_rd_ready = 1'b0;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic              mem_rsp_valid = 1'b0;
  logic              mem_rsp_err = 1'b0;
  logic [127:0]      mem_rsp_data = '0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_remap_lookup #(.ADDR_W(ADDR_W)) u_irq_remap_lookup (
    .clk, .rst, .remap_en, .root_base, .req_valid, .req_ready, .req_entry,
    .rsp_valid, .rsp_fault, .rsp_trig, .rsp_vec, .rsp_dlv, .rsp_dest,
    .rsp_dmode, .rsp_vec_warn, .mem_rd_valid, .mem_rd_ready, .mem_rd_addr,
    .mem_rsp_valid, .mem_rsp_err, .mem_rsp_data
  );

  function automatic logic [63:0] mk_req(input logic fmt, input logic [15:0] idx,
                                         input logic trig, input logic [7:0] vec);
    return {idx[14:0], fmt, 32'h0, trig, 3'b000, idx[15], 3'b000, vec};
  endfunction

  function automatic logic [127:0] mk_ent(input logic p, input logic dm, input logic trig,
                                          input logic [2:0] dlv, input logic [7:0] vec,
                                          input logic [31:0] dest);
    return {64'h0, dest, 8'h00, vec, 8'h00, dlv, trig, 2'b00, dm, p};
  endfunction

  typedef struct packed {
    logic [63:0] req;
    logic [15:0] idx;
    logic        rd;
    logic [2:0]  flt;
    logic        trig;
    logic [2:0]  dlv;
    logic [7:0]  vec;
    logic [7:0]  dest;
    logic        dm;
    logic        warn;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [0:NV-1] = '{
    '{mk_req(1, 16'd1, 0, 8'h31), 16'd1, 1'b1, 3'd0, 1'b0, 3'd1, 8'h31, 8'hA5, 1'b1, 1'b0}, // R6
    '{mk_req(1, 16'd2, 1, 8'h42), 16'd2, 1'b1, 3'd0, 1'b1, 3'd0, 8'h42, 8'h7F, 1'b0, 1'b0}, // R6
    '{mk_req(1, 16'd2, 1, 8'h10), 16'd2, 1'b1, 3'd0, 1'b1, 3'd0, 8'h42, 8'h7F, 1'b0, 1'b1}, // R8
    '{mk_req(1, 16'd1, 1, 8'h31), 16'd1, 1'b1, 3'd6, 1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0}, // R7
    '{mk_req(1, 16'd2, 0, 8'h42), 16'd2, 1'b1, 3'd6, 1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0}, // R7
    '{mk_req(0, 16'd1, 0, 8'h31), 16'd1, 1'b0, 3'd1, 1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0}, // R1
    '{mk_req(1, 16'd1, 0, 8'h31) | 64'h200, 16'd1, 1'b0, 3'd2, 1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0}, // R2
    '{mk_req(1, 16'd1, 0, 8'h31) | (64'h1 << 40), 16'd1, 1'b0, 3'd2, 1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0}, // R2
    '{mk_req(0, 16'd1, 0, 8'h31) | 64'h2000, 16'd1, 1'b0, 3'd1, 1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0}, // R1 priority
    '{mk_req(1, 16'd3, 0, 8'h00), 16'd3, 1'b1, 3'd4, 1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0}, // R4
    '{mk_req(1, 16'd7, 0, 8'h00), 16'd7, 1'b1, 3'd4, 1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0}, // R4 priority
    '{mk_req(1, 16'd4, 0, 8'h55), 16'd4, 1'b1, 3'd5, 1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0}, // R5
    '{mk_req(1, 16'd5, 0, 8'h66), 16'd5, 1'b1, 3'd5, 1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0}, // R5
    '{mk_req(1, 16'h8001, 0, 8'h00), 16'h8001, 1'b1, 3'd3, 1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0}, // R3 R4
    '{mk_req(1, 16'd6, 1, 8'hFF), 16'd6, 1'b1, 3'd0, 1'b1, 3'd5, 8'hFF, 8'hFF, 1'b1, 1'b0}, // R6
    '{mk_req(1, 16'd63, 0, 8'h01), 16'd63, 1'b1, 3'd0, 1'b0, 3'd2, 8'h01, 8'h01, 1'b0, 1'b0}  // R3 R6
  };

  logic [127:0] tbl [0:63];

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int stall);
    logic [31:0] exp_addr;
    exp_addr = BASE + {12'h0, v.idx, 4'h0};
    @(negedge clk);
    chk("R10 ready before request", 128'(req_ready), 128'd1);
    req_valid = 1'b1;
    req_entry = v.req;
    @(negedge clk);
    req_valid = 1'b0;
    req_entry = '0;
    chk("R10 ready low after accept", 128'(req_ready), 128'd0);
    if (v.rd) begin
      chk("R3 read issued", 128'(mem_rd_valid), 128'd1);
      chk("R3 read address", 128'(mem_rd_addr), 128'(exp_addr));
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk("R3 read held", 128'(mem_rd_valid), 128'd1);
        chk("R3 address stable", 128'(mem_rd_addr), 128'(exp_addr));
      end
      mem_rd_ready = 1'b1;
      @(negedge clk);
      mem_rd_ready = 1'b0;
      chk("R10 no early response", 128'(rsp_valid), 128'd0);
      @(negedge clk);
      chk("R10 ready low while waiting", 128'(req_ready), 128'd0);
      mem_rsp_valid = 1'b1;
      if (v.idx < 16'd64) begin
        mem_rsp_err  = 1'b0;
        mem_rsp_data = tbl[v.idx[5:0]];
      end else begin
        mem_rsp_err  = 1'b1;
        mem_rsp_data = {4{32'hDEAD_BEEF}};
      end
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_err   = 1'b0;
      mem_rsp_data  = '0;
    end else begin
      chk("R1 R2 no read on request fault", 128'(mem_rd_valid), 128'd0);
    end
    chk("R10 response pulse", 128'(rsp_valid), 128'd1);
    chk("R4 R5 R7 fault code", 128'(rsp_fault), 128'(v.flt));
    chk("R6 trigger", 128'(rsp_trig), 128'(v.trig));
    chk("R6 delivery", 128'(rsp_dlv), 128'(v.dlv));
    chk("R8 vector", 128'(rsp_vec), 128'(v.vec));
    chk("R6 destination", 128'(rsp_dest), 128'(v.dest));
    chk("R6 dest mode", 128'(rsp_dmode), 128'(v.dm));
    chk("R8 warn", 128'(rsp_vec_warn), 128'(v.warn));
    @(negedge clk);
    chk("R10 single pulse", 128'(rsp_valid), 128'd0);
    chk("R10 ready returns", 128'(req_ready), 128'd1);
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) tbl[i] = '0;
    tbl[1]  = mk_ent(1, 1, 0, 3'd1, 8'h31, 32'h0000_A500);
    tbl[2]  = mk_ent(1, 0, 1, 3'd0, 8'h42, 32'h0000_7F00);
    tbl[4]  = mk_ent(1, 0, 0, 3'd0, 8'h55, 32'h0000_1100) | (128'h1 << 70);
    tbl[5]  = mk_ent(1, 0, 0, 3'd0, 8'h66, 32'h0000_8001);
    tbl[6]  = mk_ent(1, 1, 1, 3'd5, 8'hFF, 32'h0000_FF00);
    tbl[7]  = 128'h1 << 100;
    tbl[63] = mk_ent(1, 0, 0, 3'd2, 8'h01, 32'h0000_0100);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset ready", 128'(req_ready), 128'd1);
    chk("R11 reset no response", 128'(rsp_valid), 128'd0);
    chk("R11 reset no read", 128'(mem_rd_valid), 128'd0);

    remap_en = 1'b0;
    @(negedge clk);
    chk("R9 ready low when disabled", 128'(req_ready), 128'd0);
    remap_en = 1'b1;
    @(negedge clk);
    chk("R9 ready back when enabled", 128'(req_ready), 128'd1);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i % 3);

    // reset during an outstanding read
    @(negedge clk);
    req_valid = 1'b1;
    req_entry = VECS[0].req;
    @(negedge clk);
    req_valid = 1'b0;
    req_entry = '0;
    chk("R11 read pending before reset", 128'(mem_rd_valid), 128'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 read dropped by reset", 128'(mem_rd_valid), 128'd0);
    chk("R11 no response after reset", 128'(rsp_valid), 128'd0);
    chk("R11 ready after reset", 128'(req_ready), 128'd1);
    run_vec(VECS[0], 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule